// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory Bus Emulator

This block stands in for a byte-wide non-volatile memory on an asynchronous processor bus. The bus has a 15-bit address, an 8-bit data path split into input, output and output-enable pins, and three active-low strobes: chip select, output enable and write enable. A fast system clock samples the strobes through two-flop synchronizers. The block decodes read cycles and byte-write cycles from them and serves both against an on-chip byte array.

A write is captured on the rising edge of write enable. The block then goes busy for a programmable number of clock cycles, which models the internal programming time. During that window, further writes are dropped and reads return a completion poll on bit 7 instead of array data. The byte is committed to the array when the window ends. A write-inhibit input blocks every write, which models protection at power-up.

The bus has no handshake and no back-pressure. A write that arrives while the block is busy or inhibited is lost, so the bus master is expected to poll bit 7 or watch `busy` before it issues the next write.

Top module: `eeprom_emu`

## Requirements
- R1: The array holds 2**ARR_AW bytes. A byte is selected by the low ARR_AW address bits, and higher address bits alias. With ARR_AW = 15 the array is a full linear 32K x 8 space from 0x0000 to 0x7FFF.
- R2: A read is decoded when ce_n = 0, oe_n = 0 and we_n = 1, as seen after the two-flop synchronizer. `dq_oe` goes high two clock edges after the strobes settle.
- R3: `dq_oe` is low whenever ce_n or oe_n is high, and also from reset until a read is decoded. `dq_o` is 0 whenever `dq_oe` is low.
- R4: A write is accepted on the synchronized rising edge of we_n while ce_n = 0 and oe_n = 1. The address and data pins are captured in that cycle, and a later read of that address returns the byte.
- R5: `busy` rises on the clock edge after a write is accepted and stays high for exactly BUSY_CYCLES cycles.
- R6: A write attempted while `busy` is high is ignored: the array does not change and the busy window is not restarted.
- R7: While `busy` is high, a read returns the complement of the captured bit 7 on dq_o[7] and zero on dq_o[6:0]. Once `busy` is low, reads return the array contents, so bit 7 then equals the written bit 7.
- R8: The array byte changes only when the busy window ends.
- R9: While wr_inhibit is high (it is tied high during reset), no write is accepted and `busy` stays low.
- R10: A we_n pulse with oe_n low is not a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_inhibit | input | 1 | Blocks all writes when high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address |
| dq_i | input | 8 | Write data from the bus |
| dq_o | output | 8 | Read data to the bus |
| dq_oe | output | 1 | Drive enable for dq_o; the bus is high-impedance when low |
| busy | output | 1 | High during the internal programming window |

## Verification
The bench builds the block with ARR_AW = 11 and BUSY_CYCLES = 40. The 2K array makes aliasing of the top address bits observable through a write at 0x7FFF and a read at 0x07FF. A 40-cycle window is short enough to measure exactly by counting cycles. It is also long enough that a polling read and a complete write attempt both fit inside one busy period.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

  function automatic logic [7:0] poll_word(input logic written_b7);
    return {~written_b7, 7'b0};
  endfunction
endpackage

// File: rtl/eeprom_sync.sv
module eeprom_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
  import eeprom_pkg::*;
#(
  parameter int AW          = 15,
  parameter int BUSY_CYCLES = 500000,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_inhibit,
  input  strobes_t      strb,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          busy,
  output logic          commit,
  output logic [AW-1:0] cap_addr,
  output logic [7:0]    cap_data
);
  logic             we_prev;
  logic [CNT_W-1:0] remain;
  logic             we_rise;
  logic             accept;

  assign we_rise = strb.we_n && !we_prev;
  assign accept  = we_rise && !strb.ce_n && strb.oe_n && !busy && !wr_inhibit;
  assign commit  = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev  <= 1'b1;
      busy     <= 1'b0;
      remain   <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      we_prev <= strb.we_n;
      if (accept) begin
        busy     <= 1'b1;
        remain   <= CNT_W'(BUSY_CYCLES - 1);
        cap_addr <= addr;
        cap_data <= din;
      end else if (commit) begin
        busy <= 1'b0;
      end else if (busy) begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int AW = 11,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_emu.sv
module eeprom_emu
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int ARR_AW      = 11,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_inhibit,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  output logic              busy
);
  strobes_t          strb_raw, strb;
  logic              commit;
  logic [ARR_AW-1:0] cap_addr;
  logic [7:0]        cap_data;
  logic [7:0]        arr_q;

  assign strb_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

  eeprom_sync #(.W(3), .RST_VAL(STROBES_IDLE)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb)
  );

  eeprom_wr_ctrl #(.AW(ARR_AW), .BUSY_CYCLES(BUSY_CYCLES)) i_wr (
    .clk(clk), .rst_n(rst_n), .wr_inhibit(wr_inhibit), .strb(strb),
    .addr(addr[ARR_AW-1:0]), .din(dq_i), .busy(busy), .commit(commit),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  eeprom_array #(.AW(ARR_AW)) i_arr (
    .clk(clk), .wr_en(commit), .wr_addr(cap_addr), .wr_data(cap_data),
    .rd_addr(addr[ARR_AW-1:0]), .rd_data(arr_q)
  );

  always_comb begin
    dq_oe = !strb.ce_n && !strb.oe_n && strb.we_n;
    if (!dq_oe)    dq_o = '0;
    else if (busy) dq_o = poll_word(cap_data[7]);
    else           dq_o = arr_q;
  end
endmodule

// File: rtl/eeprom_emu_chk.sv
module eeprom_emu_chk #(
  parameter int BUSY_CYCLES = 500000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_inhibit,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic [7:0] dq_o,
  input logic       dq_oe,
  input logic       busy
);
  logic [1:0]  since_rst;
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      run       <= '0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
      run <= busy ? run + 1 : 32'd0;
    end
  end

  p_read_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |->
      (dq_oe == (!$past(ce_n, 2) && !$past(oe_n, 2) && $past(we_n, 2))));

  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_o == 8'h00));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == BUSY_CYCLES));

  p_busy_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < BUSY_CYCLES));

  p_poll_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> (dq_o[6:0] == 7'h00));

  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inhibit && !busy) |=> !busy);
endmodule

bind eeprom_emu eeprom_emu_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_inhibit(wr_inhibit), .ce_n(ce_n),
  .oe_n(oe_n), .we_n(we_n), .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy)
);

// File: tb/test_eeprom_emu.sv
module test_eeprom_emu;
  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_inhibit = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe, busy;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  eeprom_emu #(.ADDR_W(15), .ARR_AW(11), .BUSY_CYCLES(BUSY)) i_eeprom_emu (
    .clk(clk), .rst_n(rst_n), .wr_inhibit(wr_inhibit), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .busy(busy)
  );

  // {address, data}: write then read back
  localparam logic [22:0] VEC [6] = '{
    {15'h0000, 8'h11}, {15'h07FF, 8'hA5}, {15'h0123, 8'h3C},
    {15'h0400, 8'hFF}, {15'h0001, 8'h00}, {15'h0555, 8'h80}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [14:0] a, input logic [7:0] d, input logic oe_lvl);
    addr = a; dq_i = d; ce_n = 1'b0; oe_n = oe_lvl; we_n = 1'b0;
    idle(3);
    we_n = 1'b1;
    idle(3);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(1);
  endtask

  task automatic bus_read(input logic [14:0] a, output logic [7:0] d, output logic oe);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    idle(3);
    d = dq_o; oe = dq_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    idle(3);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    int         cnt;
    idle(4);
    // R3: bus released and not busy out of reset
    check("R3 oe after reset", dq_oe, 0);
    check("R3 data after reset", dq_o, 0);
    check("R5 busy after reset", busy, 0);
    // R9: writes blocked while wr_inhibit high
    bus_write(15'h0010, 8'h5A, 1'b1);
    check("R9 inhibited write no busy", busy, 0);
    rst_n = 1'b1;
    idle(2);
    bus_write(15'h0010, 8'h5A, 1'b1);
    check("R9 inhibited write after reset", busy, 0);
    wr_inhibit = 1'b0;
    idle(2);

    // R1 R4 R8: table of writes and read-backs
    foreach (VEC[i]) begin
      bus_write(VEC[i][22:8], VEC[i][7:0], 1'b1);
      wait_idle();
      bus_read(VEC[i][22:8], rd, oe);
      check("R2 read enable", oe, 1);
      check("R4 read back", rd, VEC[i][7:0]);
    end

    // R1: high address bits alias onto the 2K array
    bus_write(15'h7FFF, 8'h6E, 1'b1);
    wait_idle();
    bus_read(15'h07FF, rd, oe);
    check("R1 alias read", rd, 8'h6E);

    // R3: output disabled when only ce_n or only oe_n is low
    addr = 15'h0123; ce_n = 1'b0; oe_n = 1'b1; idle(3);
    check("R3 oe_n high", dq_oe, 0);
    check("R3 data zero", dq_o, 0);
    ce_n = 1'b1; oe_n = 1'b0; idle(3);
    check("R3 ce_n high", dq_oe, 0);
    oe_n = 1'b1; idle(2);

    // R10: we_n pulse with oe_n low is not a write
    bus_write(15'h0123, 8'h99, 1'b0);
    check("R10 no busy", busy, 0);
    bus_read(15'h0123, rd, oe);
    check("R10 data kept", rd, 8'h3C);

    // R5: busy length, counted from the we_n rise
    addr = 15'h0200; dq_i = 8'hC3; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    idle(3);
    we_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i == 4) begin ce_n = 1'b1; end
      if (busy) cnt++;
    end
    check("R5 busy cycles", cnt, BUSY);

    // R7 R6 R8: poll during busy, write while busy dropped
    bus_write(15'h0300, 8'hA5, 1'b1);
    check("R5 busy set", busy, 1);
    bus_read(15'h0300, rd, oe);
    check("R7 poll bit7 low", rd, 8'h00);
    bus_write(15'h0301, 8'h77, 1'b1);
    bus_read(15'h0300, rd, oe);
    check("R7 still polling", rd, 8'h00);
    wait_idle();
    bus_read(15'h0300, rd, oe);
    check("R7 data after done", rd, 8'hA5);
    bus_read(15'h0301, rd, oe);
    check("R6 dropped write", rd === 8'h77 ? 1 : 0, 0);
    check("R6 no second busy", busy, 0);

    bus_write(15'h0301, 8'h3C, 1'b1);
    bus_read(15'h0301, rd, oe);
    check("R7 poll bit7 high", rd, 8'h80);
    wait_idle();
    bus_read(15'h0301, rd, oe);
    check("R8 committed", rd, 8'h3C);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule